// File: doc/BRIEF.md
# Multi-Cycle FP Issue Hazard Checker

This block is the issue logic in the decode stage of an in-order pipeline. It serves four execution paths, all with fixed timing: a one-stage integer/memory path, a pipelined FP adder, a pipelined FP multiplier and an unpipelined FP divider. Each cycle the decode stage presents at most one decoded instruction. The instruction carries an operation class, a destination register and up to two source registers, each source with its own "used" flag. The block then decides whether the instruction leaves decode this cycle (`issue`) or stays there (`stall`). A stalled instruction is held upstream, and a bubble goes into execute.

Every operation class has a known number of execute stages. At issue, the block therefore knows in which future cycle the instruction will occupy the single memory stage, and in which cycle it will use the single register write port one cycle later. It keeps three kinds of state:

- a shift register of future memory-stage claims;
- a per-register countdown until a pending result can be forwarded;
- a per-register countdown until that result is written back.

It also keeps a busy counter for the divider. With this state it detects read-after-write, write-after-write, memory/write-port and divider conflicts. For each instruction that issues, it reports how many cycles pass before a dependent instruction may issue.

Top module: `fpi_issue_ctl`

## Requirements
- R1: After reset, no hazard is recorded: `ex_valid` is 0, `stall` and `issue` are 0 while `in_valid` is 0, and the first instruction presented issues in the same cycle.
- R2: `issue` equals `in_valid` with no hazard flag raised. In the cycle after a cycle where `in_valid` and `stall` are both 1, `ex_valid` is 0 (a bubble).
- R3: One cycle after an issue, `ex_valid` is 1 and `ex_cls` equals the issued class. The class encoding is 0 integer, 1 load, 2 store, 3 FP add, 4 FP multiply, 5 FP divide; codes 6 and 7 behave as integer.
- R4: A consumer whose used source was written by an instruction issued in cycle t issues no earlier than t+1 for integer, t+4 for FP add, t+7 for FP multiply and t+25 for FP divide.
- R5: A consumer of a load result issues no earlier than two cycles after the load, which is one extra decode cycle compared with an integer producer.
- R6: An instruction issued in cycle t with S execute stages (1 for integer/load/store, 4 add, 7 multiply, 25 divide) occupies the memory stage in cycle t+1+S. It stalls while that cycle is already claimed.
- R7: A divide issues no earlier than 25 cycles after the previous divide.
- R8: An instruction writing a register that has a pending write issues only once its own write-back (cycle t+2+S) falls strictly after the pending one.
- R9: While `issue` is 1, `fwd_delay` gives the cycles until a dependent instruction may issue: 1 integer, 2 load, 0 store, 4 add, 7 multiply, 25 divide.
- R10: A source whose used flag is 0 never causes a stall, even when its register has a pending write.
- R11: Independent instructions with distinct memory cycles issue back to back, even though they complete out of program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded instruction is present |
| in_cls | input | 3 | Operation class (R3 encoding) |
| in_dst | input | 5 | Destination register |
| in_src_a | input | 5 | First source register |
| in_use_a | input | 1 | First source is read |
| in_src_b | input | 5 | Second source register |
| in_use_b | input | 1 | Second source is read |
| issue | output | 1 | Instruction leaves decode this cycle |
| stall | output | 1 | Instruction is held in decode |
| haz_raw | output | 1 | Read-after-write hazard |
| haz_waw | output | 1 | Write-after-write ordering hazard |
| haz_slot | output | 1 | Memory stage / write port already claimed |
| haz_div | output | 1 | Divider still busy |
| fwd_delay | output | 5 | Cycles until the issued result can be consumed |
| ex_valid | output | 1 | Execute stage holds an instruction (0 = bubble) |
| ex_cls | output | 3 | Class of the instruction in execute |

## Verification
The bench builds the block with its default parameters: 32 registers, four add stages, seven multiply stages, and a divider with 25 stages and an initiation interval of 25. With these values a divide claims the deepest entry of the reservation shift register, and a second divide has to wait out the full busy window. Both extremes of the countdown and claim widths are therefore exercised. The adder and multiplier depths make the memory-slot collision and the write-after-write delay land on small, countable cycle offsets, which the scoreboard compares exactly.

// File: rtl/fpi_pkg.sv
package fpi_pkg;

  typedef enum logic [2:0] {
    CLS_INT   = 3'd0,
    CLS_LOAD  = 3'd1,
    CLS_STORE = 3'd2,
    CLS_FADD  = 3'd3,
    CLS_FMUL  = 3'd4,
    CLS_FDIV  = 3'd5
  } op_cls_e;

  // number of execute stages the class spends before the memory stage
  function automatic int unsigned exec_stages(op_cls_e c, int unsigned add_s,
                                              int unsigned mul_s, int unsigned div_s);
    case (c)
      CLS_FADD: return add_s;
      CLS_FMUL: return mul_s;
      CLS_FDIV: return div_s;
      default:  return 1;
    endcase
  endfunction

  // cycles after issue before a dependent instruction may issue
  function automatic int unsigned ready_delay(op_cls_e c, int unsigned stages);
    case (c)
      CLS_LOAD:  return stages + 1;
      CLS_STORE: return 0;
      default:   return stages;
    endcase
  endfunction

  function automatic logic writes_reg(op_cls_e c);
    return c != CLS_STORE;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/fpi_slot_ring.sv
module fpi_slot_ring #(
  parameter int unsigned DEPTH = 27,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] claim_idx,
  input  logic          claim,
  output logic          slot_taken
);
  // bit k set: memory stage (and the write port one cycle later) is claimed k cycles from now
  logic [DEPTH-1:0] res_q;
  logic [DEPTH-1:0] claim_vec;
  logic [DEPTH-1:0] res_d;

  always_comb begin
    claim_vec = '0;
    if (claim) claim_vec[claim_idx] = 1'b1;
    res_d = (res_q | claim_vec) >> 1;
  end

  assign slot_taken = res_q[claim_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  // R6
  no_double_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> !res_q[claim_idx]);

  // R6
  claim_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> res_q[$past(claim_idx) - IW'(1)]);

endmodule

// File: rtl/fpi_div_track.sv
module fpi_div_track #(
  parameter int unsigned II = 25,
  localparam int unsigned BW = $clog2(II + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [BW-1:0] left_q;

  assign busy = (left_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     left_q <= '0;
    else if (start) left_q <= BW'(II - 1);
    else if (busy)  left_q <= left_q - BW'(1);
  end

  // R7
  no_div_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: rtl/fpi_reg_board.sv
module fpi_reg_board #(
  parameter int unsigned NREG = 32,
  parameter int unsigned CW   = 5,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_reg,
  input  logic [CW-1:0] wr_ready,
  input  logic [CW-1:0] wr_wb,
  input  logic [RW-1:0] rd_a,
  input  logic [RW-1:0] rd_b,
  input  logic [RW-1:0] rd_d,
  output logic [CW-1:0] ready_a,
  output logic [CW-1:0] ready_b,
  output logic [CW-1:0] wb_d
);
  logic [CW-1:0] rdy_q [NREG];
  logic [CW-1:0] wb_q  [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rst_n) begin
        rdy_q[i] <= '0;
        wb_q[i]  <= '0;
      end else if (wr_en && wr_reg == RW'(i)) begin
        rdy_q[i] <= wr_ready;
        wb_q[i]  <= wr_wb;
      end else begin
        if (rdy_q[i] != '0) rdy_q[i] <= rdy_q[i] - CW'(1);
        if (wb_q[i]  != '0) wb_q[i]  <= wb_q[i]  - CW'(1);
      end
    end
  end

  assign ready_a = rdy_q[rd_a];
  assign ready_b = rdy_q[rd_b];
  assign wb_d    = wb_q[rd_d];

  for (genvar g = 0; g < NREG; g++) begin : g_mono
    // R4
    countdown_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_reg == RW'(g)) |=> rdy_q[g] <= $past(rdy_q[g]));
  end

endmodule

// File: rtl/fpi_issue_ctl.sv
module fpi_issue_ctl
  import fpi_pkg::*;
#(
  parameter int unsigned NREG       = 32,
  parameter int unsigned ADD_STAGES = 4,
  parameter int unsigned MUL_STAGES = 7,
  parameter int unsigned DIV_STAGES = 25,
  parameter int unsigned DIV_II     = 25,
  localparam int unsigned RW   = $clog2(NREG),
  localparam int unsigned MAXS = max3(ADD_STAGES, MUL_STAGES, DIV_STAGES),
  localparam int unsigned RING = MAXS + 2,
  localparam int unsigned IW   = $clog2(RING),
  localparam int unsigned CW   = $clog2(MAXS + 3)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    in_cls,
  input  logic [RW-1:0] in_dst,
  input  logic [RW-1:0] in_src_a,
  input  logic          in_use_a,
  input  logic [RW-1:0] in_src_b,
  input  logic          in_use_b,
  output logic          issue,
  output logic          stall,
  output logic          haz_raw,
  output logic          haz_waw,
  output logic          haz_slot,
  output logic          haz_div,
  output logic [CW-1:0] fwd_delay,
  output logic          ex_valid,
  output logic [2:0]    ex_cls
);
  op_cls_e       cls;
  int unsigned   stg;
  logic [IW-1:0] mem_off;
  logic [CW-1:0] ready_v;
  logic [CW-1:0] wb_v;
  logic          writes;

  logic [CW-1:0] ready_a, ready_b, wb_d;
  logic          slot_taken, div_busy;
  logic          board_wr, div_start;

  always_comb begin
    cls     = op_cls_e'(in_cls);
    stg     = exec_stages(cls, ADD_STAGES, MUL_STAGES, DIV_STAGES);
    mem_off = IW'(stg + 1);
    ready_v = CW'(ready_delay(cls, stg));
    wb_v    = CW'(stg + 2);
    writes  = writes_reg(cls);
  end

  fpi_reg_board #(.NREG(NREG), .CW(CW)) u_board (
    .clk(clk), .rst_n(rst_n),
    .wr_en(board_wr), .wr_reg(in_dst),
    .wr_ready(ready_v - CW'(1)), .wr_wb(wb_v - CW'(1)),
    .rd_a(in_src_a), .rd_b(in_src_b), .rd_d(in_dst),
    .ready_a(ready_a), .ready_b(ready_b), .wb_d(wb_d)
  );

  fpi_slot_ring #(.DEPTH(RING)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .claim_idx(mem_off), .claim(issue), .slot_taken(slot_taken)
  );

  fpi_div_track #(.II(DIV_II)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .busy(div_busy)
  );

  assign haz_raw  = in_valid && ((in_use_a && ready_a != '0) ||
                                 (in_use_b && ready_b != '0));
  assign haz_waw  = in_valid && writes && (wb_d >= wb_v);
  assign haz_slot = in_valid && slot_taken;
  assign haz_div  = in_valid && (cls == CLS_FDIV) && div_busy;

  assign stall     = haz_raw || haz_waw || haz_slot || haz_div;
  assign issue     = in_valid && !stall;
  assign board_wr  = issue && writes;
  assign div_start = issue && (cls == CLS_FDIV);
  assign fwd_delay = ready_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_valid <= 1'b0;
      ex_cls   <= '0;
    end else begin
      ex_valid <= issue;
      ex_cls   <= issue ? in_cls : 3'd0;
    end
  end

  // R2
  stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && stall) |=> !ex_valid);

  // R3
  issue_enters_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (ex_valid && ex_cls == $past(in_cls)));

  // R10
  unused_src_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_use_a && !in_use_b) |-> !haz_raw);

endmodule

// File: tb/test_fpi_issue_ctl.sv
module test_fpi_issue_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [2:0] in_cls = '0;
  logic [4:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic       in_use_a = 1'b0, in_use_b = 1'b0;
  logic       issue, stall, haz_raw, haz_waw, haz_slot, haz_div, ex_valid;
  logic [4:0] fwd_delay;
  logic [2:0] ex_cls;

  localparam logic [2:0] K_INT = 3'd0, K_LD = 3'd1, K_ST = 3'd2,
                         K_ADD = 3'd3, K_MUL = 3'd4, K_DIV = 3'd5;

  fpi_issue_ctl i_fpi_issue_ctl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_use_a(in_use_a),
    .in_src_b(in_src_b), .in_use_b(in_use_b), .issue(issue), .stall(stall),
    .haz_raw(haz_raw), .haz_waw(haz_waw), .haz_slot(haz_slot), .haz_div(haz_div),
    .fwd_delay(fwd_delay), .ex_valid(ex_valid), .ex_cls(ex_cls)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int base = 0;
  int n_tests = 0;
  int n_fail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int         q_cyc[$];
  int         q_fwd[$];
  logic [2:0] q_cls[$];
  string      q_tag[$];

  function automatic int fwd_of(logic [2:0] c);
    case (c)
      K_LD:    return 2;
      K_ST:    return 0;
      K_ADD:   return 4;
      K_MUL:   return 7;
      K_DIV:   return 25;
      default: return 1;
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: called just after a falling edge; pushes the expectation and waits for issue
  task automatic send(logic [2:0] c, int d, int sa, bit ua, int sb, bit ub,
                      int off, string tag);
    q_cyc.push_back(base + off);
    q_fwd.push_back(fwd_of(c));
    q_cls.push_back(c);
    q_tag.push_back(tag);
    in_valid = 1'b1; in_cls = c; in_dst = 5'(d);
    in_src_a = 5'(sa); in_use_a = ua; in_src_b = 5'(sb); in_use_b = ub;
    #1;
    while (!issue) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0; in_use_a = 1'b0; in_use_b = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic start_seq();
    base = cyc;
  endtask

  // monitor: pops the scoreboard on each issue and checks execute-stage results
  bit         ex_due = 1'b0;
  logic [2:0] ex_exp = '0;
  bit         prev_stall = 1'b0;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (ex_due)
        check(ex_valid && ex_cls == ex_exp, "R3", "ex_cls", int'(ex_cls), int'(ex_exp));
      else if (prev_stall)
        check(!ex_valid, "R2", "bubble ex_valid", int'(ex_valid), 0);
      ex_due = 1'b0;
      if (issue) begin
        if (q_cyc.size() == 0) begin
          check(1'b0, "R2", "unexpected issue at cycle", cyc, -1);
        end else begin
          int         e_c;
          int         e_f;
          logic [2:0] e_k;
          string      e_t;
          e_c = q_cyc.pop_front(); e_f = q_fwd.pop_front();
          e_k = q_cls.pop_front(); e_t = q_tag.pop_front();
          check(cyc == e_c, e_t, "issue cycle offset", cyc - base, e_c - base);
          check(int'(fwd_delay) == e_f, "R9", "fwd_delay", int'(fwd_delay), e_f);
          ex_due = 1'b1;
          ex_exp = e_k;
        end
      end
      prev_stall = in_valid && stall;
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R2", "watchdog expired at cycle", cyc, 20000);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R1: clean state after reset
    check(!ex_valid, "R1", "ex_valid after reset", int'(ex_valid), 0);
    check(!stall && !issue, "R1", "stall|issue while idle", int'(stall | issue), 0);
    @(negedge clk);

    // load, dependent add, dependent store
    start_seq();
    send(K_LD,  2, 0, 0, 0, 0, 0, "R1");
    send(K_ADD, 6, 2, 1, 1, 1, 2, "R5");
    send(K_ST,  0, 6, 1, 2, 0, 6, "R4");
    idle(40);

    // independent multiply, add, load, store: back to back
    start_seq();
    send(K_MUL, 10, 0, 0, 0, 0, 0, "R11");
    send(K_ADD, 12, 0, 0, 0, 0, 1, "R11");
    send(K_LD,  14, 0, 0, 0, 0, 2, "R11");
    send(K_ST,  0, 15, 1, 0, 0, 3, "R11");
    idle(40);

    // memory slot collision: fourth op would share the add's memory cycle
    start_seq();
    send(K_ADD, 4, 0, 0, 0, 0, 0, "R6");
    send(K_INT, 5, 0, 0, 0, 0, 1, "R6");
    send(K_INT, 6, 0, 0, 0, 0, 2, "R6");
    send(K_INT, 7, 0, 0, 0, 0, 4, "R6");
    idle(40);

    // divider occupancy
    start_seq();
    send(K_DIV, 20, 0, 0, 0, 0, 0, "R7");
    send(K_DIV, 21, 0, 0, 0, 0, 25, "R7");
    idle(40);

    // divide result consumer, then divide after it
    start_seq();
    send(K_DIV, 8, 0, 0, 0, 0, 0, "R7");
    send(K_INT, 1, 8, 1, 0, 0, 25, "R4");
    send(K_DIV, 9, 0, 0, 0, 0, 26, "R7");
    idle(40);

    // multiply consumer, integer back to back
    start_seq();
    send(K_MUL, 3, 0, 0, 0, 0, 0, "R4");
    send(K_ADD, 11, 0, 0, 3, 1, 7, "R4");
    send(K_INT, 1, 0, 0, 0, 0, 8, "R4");
    send(K_INT, 2, 1, 1, 0, 0, 9, "R4");
    idle(40);

    // unused source ignored; write-after-write ordering
    start_seq();
    send(K_MUL, 7, 0, 0, 0, 0, 0, "R8");
    send(K_INT, 9, 7, 0, 7, 0, 1, "R10");
    send(K_INT, 7, 0, 0, 0, 0, 7, "R8");
    idle(10);

    check(q_cyc.size() == 0, "R2", "pending issues left", q_cyc.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule